// File: doc/BRIEF.md
# Address Aging Scanner

This block ages the entries of a MAC address table. A free-running prescaler produces a long time unit. A 16-bit period, written as two bytes, sets how many units lie between scans. When a period ends, a walker visits every table entry in index order, one entry per clock. The walker holds its position in any cycle where a higher-priority requester owns the table port.

Each entry carries four flags: valid, hit, locked and aged. On a visit, a valid entry that was refreshed since the last pass loses its hit flag. A valid entry that was not refreshed and is not locked is marked aged. The aged flag stays set until the entry is refreshed or deleted, so software can later walk the aged entries. A level output tells the interrupt logic that at least one aged entry exists.

Refresh, lock and delete strobes come from the lookup engine and the register file. A combinational read port shows the flags of any entry.

Top module: `aging_scanner`

## Requirements
- R1: The prescaler unit lasts 2^PRE_W clocks. With aging enabled from an idle, zeroed state at a period of P units, `scan_active` first reads high P*2^PRE_W+1 clock edges after the enable takes effect.
- R2: The period is {`age_period_hi`, `age_period_lo`}, with the high byte forming bits 15:8.
- R3: While `age_disable` is 1, or while the period is 0, no scan starts or continues, and the prescaler and period count are held at zero.
- R4: A scan visits entries 0 to ENTRIES-1 in ascending order, one per non-busy cycle. Without a busy cycle, `scan_active` stays high for exactly ENTRIES cycles.
- R5: A cycle with `port_busy` high during a scan visits no entry and holds the scan index, which lengthens the scan by one cycle.
- R6: A visited entry that is valid with hit set has its hit flag cleared and is not marked aged.
- R7: A visited entry that is valid, not hit and not locked gets aged=1. A locked entry is never newly aged. A visit leaves an invalid entry unchanged.
- R8: An aged flag is cleared only by a refresh or a delete of that entry. Later scans leave it set.
- R9: A refresh sets valid=1, hit=1 and aged=0 on its entry. When a refresh and a visit hit the same entry in the same cycle, the refresh wins.
- R10: A delete clears valid, hit, locked and aged of its entry. A lock strobe writes `lock_val` to the locked flag.
- R11: `aged_exists` is 1 exactly when at least one entry has aged=1, and reset clears every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| age_disable | input | 1 | 1 stops aging |
| age_period_lo | input | 8 | Period bits 7:0, in units |
| age_period_hi | input | 8 | Period bits 15:8, in units |
| port_busy | input | 1 | Table port owned by a higher-priority requester this cycle |
| refresh_vld | input | 1 | Refresh strobe |
| refresh_idx | input | IDX_W | Entry to refresh |
| lock_vld | input | 1 | Lock write strobe |
| lock_idx | input | IDX_W | Entry whose lock is written |
| lock_val | input | 1 | New lock value |
| delete_vld | input | 1 | Delete strobe |
| delete_idx | input | IDX_W | Entry to delete |
| rd_idx | input | IDX_W | Entry shown on the read port |
| rd_valid | output | 1 | Valid flag of rd_idx |
| rd_hit | output | 1 | Hit flag of rd_idx |
| rd_locked | output | 1 | Locked flag of rd_idx |
| rd_aged | output | 1 | Aged flag of rd_idx |
| scan_active | output | 1 | A scan is in progress |
| aged_exists | output | 1 | Aged-address interrupt source |

## Verification
The assertions check several properties on every cycle:
- The scan index steps by exactly one per visit and holds on busy cycles.
- A locked entry never becomes aged.
- An aged flag falls only after a refresh or a delete of that entry.
- Refresh and delete leave their entry in the state the requirements give.
- Turning aging off stops any scan on the next cycle.

Only the bench scenarios can show the exact start latency for a given period, the split of the period across two bytes, and the full flag outcome for every combination of valid, hit and locked. They also show the refresh-over-visit priority and the behaviour of the interrupt level across several scans.

// File: rtl/aging_pkg.sv
package aging_pkg;
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    localparam int PERIOD_W = 16;
endpackage

// File: rtl/age_prescaler.sv
module age_prescaler #(
    parameter int PRE_W = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic unit_tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unit_tick = enable && (st_q.cnt == {PRE_W{1'b1}});

    // R3
    pre_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.cnt == '0));
endmodule

// File: rtl/age_period_ctr.sv
module age_period_ctr
    import aging_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                unit_tick,
    output logic                scan_start
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                start;
    } per_state_t;

    per_state_t st_d, st_q;
    logic [PERIOD_W:0] next_cnt;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        next_cnt   = {1'b0, st_q.cnt} + 1'b1;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (unit_tick) begin
            if (next_cnt >= {1'b0, period}) begin
                st_d.cnt   = '0;
                st_d.start = 1'b1;
            end else begin
                st_d.cnt = next_cnt[PERIOD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_start = st_q.start;

    // R1
    start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |-> $past(unit_tick));
endmodule

// File: rtl/age_scan_walker.sv
module age_scan_walker
    import aging_pkg::*;
#(
    parameter int ENTRIES = 8192,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scan_start,
    input  logic             port_busy,
    output logic             scan_active,
    output logic             visit_vld,
    output logic [IDX_W-1:0] visit_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        scan_state_e      state;
        logic [IDX_W-1:0] idx;
    } walk_state_t;

    walk_state_t st_d, st_q;

    assign scan_active = (st_q.state == SCAN_RUN);
    assign visit_vld   = scan_active && enable && !port_busy;
    assign visit_idx   = st_q.idx;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            SCAN_IDLE: begin
                if (scan_start && enable) begin
                    st_d.state = SCAN_RUN;
                    st_d.idx   = '0;
                end
            end
            SCAN_RUN: begin
                if (!enable) begin
                    st_d.state = SCAN_IDLE;
                    st_d.idx   = '0;
                end else if (!port_busy) begin
                    if (st_q.idx == LAST_IDX) begin
                        st_d.state = SCAN_IDLE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SCAN_IDLE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        visit_vld |=> ((visit_idx == $past(visit_idx) + 1'b1) ||
                       (visit_idx == '0 && !scan_active)));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_active && enable && port_busy) |=> (scan_active && $stable(visit_idx)));
endmodule

// File: rtl/age_flag_table.sv
module age_flag_table #(
    parameter int ENTRIES = 8192,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             visit_vld,
    input  logic [IDX_W-1:0] visit_idx,
    input  logic             refresh_vld,
    input  logic [IDX_W-1:0] refresh_idx,
    input  logic             lock_vld,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic             lock_val,
    input  logic             delete_vld,
    input  logic [IDX_W-1:0] delete_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_hit,
    output logic             rd_locked,
    output logic             rd_aged,
    output logic             aged_any
);
    typedef struct packed {
        logic [ENTRIES-1:0] valid;
        logic [ENTRIES-1:0] hit;
        logic [ENTRIES-1:0] locked;
        logic [ENTRIES-1:0] aged;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [ENTRIES-1:0] clear_mask;

    always_comb begin
        st_d = st_q;
        if (visit_vld && st_q.valid[visit_idx]) begin
            if (st_q.hit[visit_idx]) begin
                st_d.hit[visit_idx] = 1'b0;
            end else if (!st_q.locked[visit_idx]) begin
                st_d.aged[visit_idx] = 1'b1;
            end
        end
        if (lock_vld) begin
            st_d.locked[lock_idx] = lock_val;
        end
        if (refresh_vld) begin
            st_d.valid[refresh_idx] = 1'b1;
            st_d.hit[refresh_idx]   = 1'b1;
            st_d.aged[refresh_idx]  = 1'b0;
        end
        if (delete_vld) begin
            st_d.valid[delete_idx]  = 1'b0;
            st_d.hit[delete_idx]    = 1'b0;
            st_d.locked[delete_idx] = 1'b0;
            st_d.aged[delete_idx]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid  = st_q.valid[rd_idx];
    assign rd_hit    = st_q.hit[rd_idx];
    assign rd_locked = st_q.locked[rd_idx];
    assign rd_aged   = st_q.aged[rd_idx];
    assign aged_any  = |st_q.aged;

    always_comb begin
        clear_mask = '0;
        if (refresh_vld) clear_mask[refresh_idx] = 1'b1;
        if (delete_vld)  clear_mask[delete_idx]  = 1'b1;
    end

    // R7
    lock_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.aged & ~$past(st_q.aged) & $past(st_q.locked)) == '0));

    // R8
    aged_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.aged) & ~st_q.aged & ~$past(clear_mask)) == '0));

    // R9
    refresh_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_vld && !(delete_vld && delete_idx == refresh_idx)) |=>
        (st_q.valid[$past(refresh_idx)] && st_q.hit[$past(refresh_idx)] &&
         !st_q.aged[$past(refresh_idx)]));

    // R10
    delete_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delete_vld |=> (!st_q.valid[$past(delete_idx)] && !st_q.hit[$past(delete_idx)] &&
                        !st_q.locked[$past(delete_idx)] && !st_q.aged[$past(delete_idx)]));
endmodule

// File: rtl/aging_scanner.sv
module aging_scanner
    import aging_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int PRE_W   = 26,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             age_disable,
    input  logic [7:0]       age_period_lo,
    input  logic [7:0]       age_period_hi,
    input  logic             port_busy,
    input  logic             refresh_vld,
    input  logic [IDX_W-1:0] refresh_idx,
    input  logic             lock_vld,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic             lock_val,
    input  logic             delete_vld,
    input  logic [IDX_W-1:0] delete_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_hit,
    output logic             rd_locked,
    output logic             rd_aged,
    output logic             scan_active,
    output logic             aged_exists
);
    logic [PERIOD_W-1:0] period;
    logic                aging_en;
    logic                unit_tick;
    logic                scan_start;
    logic                visit_vld;
    logic [IDX_W-1:0]    visit_idx;

    assign period   = {age_period_hi, age_period_lo};
    assign aging_en = !age_disable && (period != '0);

    age_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (aging_en),
        .unit_tick (unit_tick)
    );

    age_period_ctr u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (aging_en),
        .period     (period),
        .unit_tick  (unit_tick),
        .scan_start (scan_start)
    );

    age_scan_walker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (aging_en),
        .scan_start  (scan_start),
        .port_busy   (port_busy),
        .scan_active (scan_active),
        .visit_vld   (visit_vld),
        .visit_idx   (visit_idx)
    );

    age_flag_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .visit_vld   (visit_vld),
        .visit_idx   (visit_idx),
        .refresh_vld (refresh_vld),
        .refresh_idx (refresh_idx),
        .lock_vld    (lock_vld),
        .lock_idx    (lock_idx),
        .lock_val    (lock_val),
        .delete_vld  (delete_vld),
        .delete_idx  (delete_idx),
        .rd_idx      (rd_idx),
        .rd_valid    (rd_valid),
        .rd_hit      (rd_hit),
        .rd_locked   (rd_locked),
        .rd_aged     (rd_aged),
        .aged_any    (aged_exists)
    );

    // R3
    off_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aging_en |=> !scan_active);
endmodule

// File: tb/aging_scanner_bench.sv
`timescale 1ns/1ps
module aging_scanner_bench;
    localparam int N  = 16;
    localparam int PW = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic age_disable = 1'b1;
    logic [7:0] age_period_lo = 8'd0;
    logic [7:0] age_period_hi = 8'd0;
    logic port_busy = 1'b0;
    logic refresh_vld = 1'b0;
    logic [IW-1:0] refresh_idx = '0;
    logic lock_vld = 1'b0;
    logic [IW-1:0] lock_idx = '0;
    logic lock_val = 1'b0;
    logic delete_vld = 1'b0;
    logic [IW-1:0] delete_idx = '0;
    logic [IW-1:0] rd_idx = '0;
    logic rd_valid, rd_hit, rd_locked, rd_aged, scan_active, aged_exists;

    logic [N-1:0] mv = '0, mh = '0, ml = '0, ma = '0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    aging_scanner #(.ENTRIES(N), .PRE_W(PW)) u_aging_scanner (
        .clk(clk), .rst_n(rst_n), .age_disable(age_disable),
        .age_period_lo(age_period_lo), .age_period_hi(age_period_hi),
        .port_busy(port_busy), .refresh_vld(refresh_vld), .refresh_idx(refresh_idx),
        .lock_vld(lock_vld), .lock_idx(lock_idx), .lock_val(lock_val),
        .delete_vld(delete_vld), .delete_idx(delete_idx), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_locked(rd_locked), .rd_aged(rd_aged),
        .scan_active(scan_active), .aged_exists(aged_exists)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            rd_idx = IW'(i);
            #1;
            chk(tag, {rd_valid, rd_hit, rd_locked, rd_aged},
                {mv[i], mh[i], ml[i], ma[i]});
        end
        chk({tag, " aged_exists"}, aged_exists, (ma != '0));
    endtask

    task automatic refresh(input int i);
        @(negedge clk);
        refresh_vld = 1'b1; refresh_idx = IW'(i);
        @(negedge clk);
        refresh_vld = 1'b0;
        mv[i] = 1'b1; mh[i] = 1'b1; ma[i] = 1'b0;
    endtask

    task automatic set_lock(input int i, input logic v);
        @(negedge clk);
        lock_vld = 1'b1; lock_idx = IW'(i); lock_val = v;
        @(negedge clk);
        lock_vld = 1'b0;
        ml[i] = v;
    endtask

    task automatic delete_entry(input int i);
        @(negedge clk);
        delete_vld = 1'b1; delete_idx = IW'(i);
        @(negedge clk);
        delete_vld = 1'b0;
        mv[i] = 1'b0; mh[i] = 1'b0; ml[i] = 1'b0; ma[i] = 1'b0;
    endtask

    // Model of one full pass, written from R6/R7.
    task automatic model_scan();
        for (int i = 0; i < N; i++) begin
            if (mv[i]) begin
                if (mh[i]) mh[i] = 1'b0;
                else if (!ml[i]) ma[i] = 1'b1;
            end
        end
    endtask

    task automatic run_scan(input logic [7:0] hi, input logic [7:0] lo, input int exp_lat,
                            input bit use_busy, input bit hold_ref, input int ref_i);
        int lat;
        int dur;
        int nb;
        @(negedge clk);
        age_period_hi = hi; age_period_lo = lo;
        if (hold_ref) begin refresh_vld = 1'b1; refresh_idx = IW'(ref_i); end
        age_disable = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!scan_active && lat < 6000);
        chk("R1 R2 start latency", lat, exp_lat);
        dur = 0; nb = 0;
        while (scan_active && dur < 200) begin
            dur++;
            if (port_busy) nb++;
            port_busy = use_busy && (dur % 3 == 1);
            @(negedge clk);
        end
        age_disable = 1'b1;
        port_busy = 1'b0;
        refresh_vld = 1'b0;
        chk(use_busy ? "R5 busy-extended length" : "R4 scan length", dur, N + nb);
        if (use_busy) chk("R5 busy cycles seen", (nb > 0), 1);
        model_scan();
        if (hold_ref) begin mv[ref_i] = 1'b1; mh[ref_i] = 1'b1; ma[ref_i] = 1'b0; end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int act;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset scan_active", scan_active, 0);
        check_all("R11 reset flags");

        // Entries with combo bit0 = valid become present; a first pass clears hit.
        for (int i = 0; i < N; i++) if (i[0]) refresh(i);
        run_scan(8'd0, 8'd1, 1 * 16 + 1, 1'b0, 1'b0, 0);
        check_all("R6 first pass clears hit");

        // combo bit2 = locked, bit1 = hit (refresh again).
        for (int i = 0; i < N; i++) if (i[2]) set_lock(i, 1'b1);
        for (int i = 0; i < N; i++) if (i[0] && i[1]) refresh(i);
        check_all("R10 lock write");
        run_scan(8'd0, 8'd3, 3 * 16 + 1, 1'b1, 1'b0, 0);
        check_all("R7 aging by combination");

        // Entry 1 is aged; hold its refresh across a pass: the refresh wins.
        run_scan(8'd0, 8'd2, 2 * 16 + 1, 1'b0, 1'b1, 1);
        check_all("R9 R8 refresh wins and aged persists");

        // Split period: high byte weighs 256.
        run_scan(8'd1, 8'd1, 257 * 16 + 1, 1'b0, 1'b0, 0);
        check_all("R8 after split-period pass");

        refresh(3);
        check_all("R9 refresh clears aged");
        delete_entry(7);
        delete_entry(5);
        check_all("R10 delete clears all");

        // R3: period zero and disable bit both keep the scan idle.
        @(negedge clk);
        age_period_hi = 8'd0; age_period_lo = 8'd0; age_disable = 1'b0;
        act = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (scan_active) act++; end
        chk("R3 zero period idle", act, 0);
        age_period_lo = 8'd1; age_disable = 1'b1;
        act = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (scan_active) act++; end
        chk("R3 disable bit idle", act, 0);
        check_all("R3 flags untouched while off");

        for (int i = 0; i < N; i++) if (ma[i]) delete_entry(i);
        check_all("R11 no aged left");
        chk("R11 aged_exists low", aged_exists, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule